// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block sits behind a serial front end and runs the command layer of a small byte-addressed non-volatile memory. The front end hands over each received byte with a strobe. It also reports when chip select rises and whether that rise came exactly after a whole byte. The sequencer decodes the opcode and then acts on it. It either streams array bytes or status bytes back for transmission, buffers a page write, or issues single-cycle command pulses to the status logic. The status logic owns the write-enable latch, the protection policy and the write-cycle timer, and in return supplies a permit flag and a busy flag.

The array holds 512 bytes. Address bit 8 is carried in bit 3 of the opcode, and the address byte that follows gives bits 7 to 0. A read streams for as long as the selection lasts, and its address wraps across the whole array. A write collects data bytes into a 16-byte page buffer, and the write offset wraps inside that page. The buffer is committed to the array in one cycle, on a clean deselect.

Top module: `spi_eeprom_seq`

## Requirements
- R1: An opcode is valid only when bits 7..4 are 0. Bits 2..0 select the command: 110 enable, 100 disable, 101 status read, 001 status write, 011 array read, 010 array write. Bit 3 is address bit 8 for array read and array write, and is ignored for the other commands.
- R2: For an array read, the byte after the opcode is address bits 7..0. One cycle after that byte's strobe, `tx_vld` pulses with the array byte at that address on `tx_byte`. Each further strobe presents the next address, and address 0x1FF is followed by 0x000.
- R3: After a status-read opcode, every strobe, including the opcode's own, gives a `tx_vld` pulse one cycle later with the value of `status_in` on `tx_byte`. This continues until deselect.
- R4: For an array write, each data byte goes to the current page at an offset that starts at address bits 3..0 and increments modulo 16. Address bits 8..4 stay fixed, so a later byte to the same offset overwrites an earlier one.
- R5: The buffered write is committed to the array, with a one-cycle `arr_wr_p` pulse, only on a chip-select rise when three conditions hold: the rise is on a byte boundary, `wr_permit` is 1, and at least one data byte was received. Otherwise the array is left unchanged.
- R6: A status write takes exactly one data byte. A following boundary deselect with `wr_permit` high gives a one-cycle `sr_wr_p` pulse with the byte on `sr_wdata`. A deselect off the boundary, a deselect with no permit, or any extra byte gives no pulse.
- R7: While `wr_busy` is 1 when the opcode arrives, array read, array write and status write are ignored until deselect. A status read is still served.
- R8: An invalid opcode makes the block ignore every further byte until deselect, with no transmit and no pulse.
- R9: An enable or disable opcode gives a one-cycle `wel_set_p` or `wel_clr_p` pulse on the chip-select rise that follows it. No pulse is given if any further byte arrived before that rise. At most one command pulse is high in any cycle.
- R10: After reset every array byte reads 0xFF, and `tx_vld` and all command pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| byte_vld | input | 1 | A received byte is complete this cycle |
| byte_in | input | 8 | Received byte |
| cs_rise | input | 1 | Chip select rose this cycle |
| cs_on_bound | input | 1 | The chip-select rise came right after a whole byte |
| wr_permit | input | 1 | Writes allowed (latch set, not protected) |
| wr_busy | input | 1 | A write cycle is in progress |
| status_in | input | 8 | Status byte to stream on a status read |
| tx_vld | output | 1 | New transmit byte ready |
| tx_byte | output | 8 | Byte to transmit |
| wel_set_p | output | 1 | Enable command pulse |
| wel_clr_p | output | 1 | Disable command pulse |
| sr_wr_p | output | 1 | Status write command pulse |
| sr_wdata | output | 8 | Status byte to write |
| arr_wr_p | output | 1 | Array write committed, write cycle start |

## Verification
Reads are tried at the bottom of the array, at a high address with bit 8 set, and across the 0x1FF to 0x000 seam, which separates address decoding from rollover. Writes are tried as a single byte, as a page-crossing burst of 18 bytes, and as bursts ended off the boundary, without permit, with no data, and under busy. A reference array in the bench tells overwrite-in-page apart from spill into the next page, and a real commit apart from a rejected one. Status reads, status writes and invalid opcodes are interleaved with these, to show that ignored selections leave the array and the pulses untouched.

// File: rtl/spi_eeprom_seq.sv
module spi_eeprom_seq #(
  parameter int PAGE_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  input  logic       cs_rise,
  input  logic       cs_on_bound,
  input  logic       wr_permit,
  input  logic       wr_busy,
  input  logic [7:0] status_in,
  output logic       tx_vld,
  output logic [7:0] tx_byte,
  output logic       wel_set_p,
  output logic       wel_clr_p,
  output logic       sr_wr_p,
  output logic [7:0] sr_wdata,
  output logic       arr_wr_p
);
  localparam int AW    = 9;
  localparam int DEPTH = 1 << AW;
  localparam int PAGE  = 1 << PAGE_W;

  typedef enum logic [3:0] {S_OP, S_ADDR, S_RD, S_ST, S_WR, S_SR, S_SRD, S_HOLD, S_IGN} st_t;

  st_t               st_q;
  logic              is_rd_q;
  logic [1:0]        wen_q;
  logic              a8_q;
  logic [AW-1:0]     addr_q;
  logic [PAGE_W-1:0] off_q;
  logic [7:0]        sr_q;
  logic [7:0]        mem  [DEPTH];
  logic [7:0]        pbuf [PAGE];
  logic [PAGE-1:0]   pmask_q;

  wire          op_ok     = (byte_in[7:4] == 4'h0);
  wire [2:0]    opc       = byte_in[2:0];
  wire [AW-1:0] full_addr = {a8_q, byte_in};
  wire          commit    = cs_rise && st_q == S_WR && |pmask_q && cs_on_bound && wr_permit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_OP;
      is_rd_q   <= 1'b0;
      wen_q     <= 2'b00;
      a8_q      <= 1'b0;
      addr_q    <= '0;
      off_q     <= '0;
      sr_q      <= 8'h00;
      pmask_q   <= '0;
      tx_vld    <= 1'b0;
      tx_byte   <= 8'h00;
      wel_set_p <= 1'b0;
      wel_clr_p <= 1'b0;
      sr_wr_p   <= 1'b0;
      sr_wdata  <= 8'h00;
      arr_wr_p  <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= 8'h00;
    end else begin
      tx_vld    <= 1'b0;
      wel_set_p <= 1'b0;
      wel_clr_p <= 1'b0;
      sr_wr_p   <= 1'b0;
      arr_wr_p  <= 1'b0;
      if (cs_rise) begin
        st_q    <= S_OP;
        pmask_q <= '0;
        if (st_q == S_HOLD) begin
          wel_set_p <= wen_q[0];
          wel_clr_p <= wen_q[1];
        end
        if (st_q == S_SRD && cs_on_bound && wr_permit) begin
          sr_wr_p  <= 1'b1;
          sr_wdata <= sr_q;
        end
        if (commit) begin
          arr_wr_p <= 1'b1;
          for (int i = 0; i < PAGE; i++)
            if (pmask_q[i]) mem[{addr_q[AW-1:PAGE_W], PAGE_W'(i)}] <= pbuf[i];
        end
      end else if (byte_vld) begin
        case (st_q)
          S_OP: begin
            st_q <= S_IGN;
            if (op_ok) begin
              case (opc)
                3'b110: begin st_q <= S_HOLD; wen_q <= 2'b01; end
                3'b100: begin st_q <= S_HOLD; wen_q <= 2'b10; end
                3'b101: begin st_q <= S_ST; tx_vld <= 1'b1; tx_byte <= status_in; end
                3'b001: if (!wr_busy) st_q <= S_SR;
                3'b011, 3'b010:
                  if (!wr_busy) begin
                    st_q    <= S_ADDR;
                    is_rd_q <= opc[0];
                    a8_q    <= byte_in[3];
                  end
                default: ;
              endcase
            end
          end
          S_ADDR: begin
            if (is_rd_q) begin
              tx_vld  <= 1'b1;
              tx_byte <= mem[full_addr];
              addr_q  <= full_addr + AW'(1);
              st_q    <= S_RD;
            end else begin
              addr_q <= full_addr;
              off_q  <= byte_in[PAGE_W-1:0];
              st_q   <= S_WR;
            end
          end
          S_RD: begin
            tx_vld  <= 1'b1;
            tx_byte <= mem[addr_q];
            addr_q  <= addr_q + AW'(1);
          end
          S_ST: begin
            tx_vld  <= 1'b1;
            tx_byte <= status_in;
          end
          S_WR: begin
            pbuf[off_q]    <= byte_in;
            pmask_q[off_q] <= 1'b1;
            off_q          <= off_q + PAGE_W'(1);
          end
          S_SR: begin
            sr_q <= byte_in;
            st_q <= S_SRD;
          end
          S_SRD, S_HOLD: st_q <= S_IGN;
          default: ;
        endcase
      end
    end
  end

  // R5
  commit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_p |-> $past(cs_rise && cs_on_bound && wr_permit));

  // R6
  sr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_p |-> $past(cs_rise && cs_on_bound && wr_permit));

  // R9
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wel_set_p, wel_clr_p, sr_wr_p, arr_wr_p}));

  // R8
  ign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IGN && byte_vld && !cs_rise) |=> !tx_vld);

  // R7
  busy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_OP && byte_vld && !cs_rise && wr_busy && byte_in[2:0] == 3'b011) |=> !tx_vld);

  // R2
  rd_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RD && byte_vld && !cs_rise) |=> (tx_vld && addr_q == $past(addr_q) + AW'(1)));
endmodule

// File: tb/spi_eeprom_seq_tb.sv
module spi_eeprom_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic       cs_rise = 1'b0;
  logic       cs_on_bound = 1'b0;
  logic       wr_permit = 1'b1;
  logic       wr_busy = 1'b0;
  logic [7:0] status_in = 8'hF0;
  logic       tx_vld, wel_set_p, wel_clr_p, sr_wr_p, arr_wr_p;
  logic [7:0] tx_byte, sr_wdata;

  int nchk = 0;
  int nerr = 0;
  logic [7:0] model [512];
  logic p_set, p_clr, p_sr, p_arr;
  logic [7:0] p_srd;

  always #2.5 clk = ~clk;

  spi_eeprom_seq dut_i (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
    .cs_rise(cs_rise), .cs_on_bound(cs_on_bound), .wr_permit(wr_permit),
    .wr_busy(wr_busy), .status_in(status_in), .tx_vld(tx_vld), .tx_byte(tx_byte),
    .wel_set_p(wel_set_p), .wel_clr_p(wel_clr_p), .sr_wr_p(sr_wr_p),
    .sr_wdata(sr_wdata), .arr_wr_p(arr_wr_p));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sb(input logic [7:0] b, output logic v, output logic [7:0] d);
    @(negedge clk);
    byte_vld = 1'b1;
    byte_in  = b;
    @(negedge clk);
    byte_vld = 1'b0;
    v = tx_vld;
    d = tx_byte;
  endtask

  task automatic ds(input logic bound);
    @(negedge clk);
    cs_rise     = 1'b1;
    cs_on_bound = bound;
    @(negedge clk);
    cs_rise     = 1'b0;
    cs_on_bound = 1'b0;
    p_set = wel_set_p; p_clr = wel_clr_p; p_sr = sr_wr_p; p_arr = arr_wr_p; p_srd = sr_wdata;
  endtask

  task automatic write_seq(input string tag, input logic [8:0] a, input int n,
                           input logic [7:0] seed, input logic bound, input logic expect_commit);
    logic v; logic [7:0] d;
    sb({4'h0, a[8], 3'b010}, v, d);
    sb(a[7:0], v, d);
    for (int k = 0; k < n; k++) sb(seed + 8'(k), v, d);
    ds(bound);
    chk(tag, p_arr, expect_commit);
    if (expect_commit)
      for (int k = 0; k < n; k++) model[{a[8:4], 4'(a[3:0] + 4'(k))}] = seed + 8'(k);
  endtask

  task automatic read_seq(input string tag, input logic [8:0] a, input int n);
    logic v; logic [7:0] d;
    sb({4'h0, a[8], 3'b011}, v, d);
    sb(a[7:0], v, d);
    chk(tag, v, 1'b1);
    chk(tag, d, model[a]);
    for (int k = 1; k < n; k++) begin
      sb(8'h00, v, d);
      chk(tag, v, 1'b1);
      chk(tag, d, model[9'(a + 9'(k))]);
    end
    ds(1'b1);
  endtask

  task automatic t_reset;
    chk("R10 tx_vld", tx_vld, 1'b0);
    chk("R10 pulses", {wel_set_p, wel_clr_p, sr_wr_p, arr_wr_p}, 4'h0);
    read_seq("R10 array", 9'h000, 3);
    read_seq("R10 array hi", 9'h1C7, 1);
  endtask

  task automatic t_enable;
    logic v; logic [7:0] d;
    sb(8'h06, v, d); ds(1'b1);
    chk("R9 enable", {p_set, p_clr}, 2'b10);
    sb(8'h04, v, d); ds(1'b1);
    chk("R9 disable", {p_set, p_clr}, 2'b01);
    sb(8'h0E, v, d); ds(1'b1);
    chk("R1 bit3 ignored on enable", {p_set, p_clr}, 2'b10);
    sb(8'h06, v, d); sb(8'h00, v, d); ds(1'b1);
    chk("R9 extra byte drops", {p_set, p_clr}, 2'b00);
  endtask

  task automatic t_write_basic;
    write_seq("R5 single commit", 9'h1F5, 1, 8'hA5, 1'b1, 1'b1);
    read_seq("R1 a8 read back", 9'h1F5, 1);
    read_seq("R1 low half untouched", 9'h0F5, 1);
  endtask

  task automatic t_page_wrap;
    write_seq("R4 wrap commit", 9'h03E, 18, 8'h10, 1'b1, 1'b1);
    read_seq("R4 page contents", 9'h030, 17);
  endtask

  task automatic t_rollover;
    write_seq("R2 top fill", 9'h1FE, 2, 8'h5A, 1'b1, 1'b1);
    write_seq("R2 base fill", 9'h000, 2, 8'hC3, 1'b1, 1'b1);
    read_seq("R2 rollover", 9'h1FE, 4);
  endtask

  task automatic t_reject;
    logic v; logic [7:0] d;
    write_seq("R5 off boundary", 9'h100, 3, 8'h77, 1'b0, 1'b0);
    wr_permit = 1'b0;
    write_seq("R5 no permit", 9'h101, 2, 8'h88, 1'b1, 1'b0);
    wr_permit = 1'b1;
    write_seq("R5 no data", 9'h102, 0, 8'h99, 1'b1, 1'b0);
    read_seq("R5 unchanged", 9'h100, 4);
  endtask

  task automatic t_status;
    logic v; logic [7:0] d;
    status_in = 8'hF2;
    sb(8'h05, v, d);
    chk("R3 first", {v, d}, {1'b1, 8'hF2});
    status_in = 8'hF3;
    sb(8'h00, v, d);
    chk("R3 repeat", {v, d}, {1'b1, 8'hF3});
    ds(1'b1);
    sb(8'h01, v, d); sb(8'h0C, v, d); ds(1'b1);
    chk("R6 status write", {p_sr, p_srd}, {1'b1, 8'h0C});
    sb(8'h01, v, d); sb(8'h08, v, d); ds(1'b0);
    chk("R6 off boundary", p_sr, 1'b0);
    wr_permit = 1'b0;
    sb(8'h01, v, d); sb(8'h08, v, d); ds(1'b1);
    chk("R6 no permit", p_sr, 1'b0);
    wr_permit = 1'b1;
    sb(8'h01, v, d); sb(8'h08, v, d); sb(8'h04, v, d); ds(1'b1);
    chk("R6 extra byte", p_sr, 1'b0);
  endtask

  task automatic t_busy;
    logic v; logic [7:0] d;
    wr_busy = 1'b1;
    sb(8'h03, v, d); sb(8'h30, v, d);
    chk("R7 read ignored", v, 1'b0);
    sb(8'h00, v, d);
    chk("R7 read stays ignored", v, 1'b0);
    ds(1'b1);
    write_seq("R7 write ignored", 9'h030, 2, 8'hEE, 1'b1, 1'b0);
    sb(8'h01, v, d); sb(8'h0C, v, d); ds(1'b1);
    chk("R7 status write ignored", p_sr, 1'b0);
    status_in = 8'hF1;
    sb(8'h05, v, d);
    chk("R7 status read served", {v, d}, {1'b1, 8'hF1});
    ds(1'b1);
    wr_busy = 1'b0;
    read_seq("R7 array unchanged", 9'h030, 2);
  endtask

  task automatic t_invalid;
    logic v; logic [7:0] d;
    sb(8'h07, v, d);
    chk("R8 invalid no tx", v, 1'b0);
    sb(8'h03, v, d); sb(8'h00, v, d);
    chk("R8 later bytes ignored", v, 1'b0);
    ds(1'b1);
    chk("R8 no pulse", {p_set, p_clr, p_sr, p_arr}, 4'h0);
    sb(8'h83, v, d); sb(8'h00, v, d);
    chk("R1 upper nibble invalid", v, 1'b0);
    ds(1'b1);
    sb(8'h42, v, d); sb(8'h00, v, d); sb(8'h12, v, d); ds(1'b1);
    chk("R1 bad write opcode", p_arr, 1'b0);
    read_seq("R8 array intact", 9'h000, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_enable;
    t_write_basic;
    t_page_wrap;
    t_rollover;
    t_reject;
    t_status;
    t_busy;
    t_invalid;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule